// File: doc/BRIEF.md
# Redial Digit Store

This block holds the digits of one telephone number so that it can be sent again later. It serves two uses: redial of the last number dialled, and a notepad number keyed in during a conversation. A new number goes into a scratch register first and replaces the stored number only when dialling of that number ends. Keying a new number therefore leaves the stored number intact until the new one is complete. A separate read pointer walks the stored number while the dial sequencer sends it again. Pulse and tone timing belong to the dial sequencer, not to this block.

The controller has four states. `ST_IDLE` means no capture and no readout. `ST_DIAL` means a new number is being captured into scratch. `ST_NOTE` means notepad digits are being written straight into the stored number. `ST_PLAY` means the stored number is being read out.

The transitions, in priority order:
- standby: any state goes to `ST_IDLE`.
- flash: any state goes to `ST_IDLE`, committing first if the state was `ST_DIAL`.
- program key: any state goes to `ST_NOTE`.
- `ST_IDLE` to `ST_PLAY`: on redial, if the number is valid and digits remain after the read pointer.
- `ST_IDLE` to `ST_DIAL`: on a digit strobe.
- `ST_DIAL` to `ST_IDLE`: on end of number, committing the scratch digits.
- `ST_NOTE` to `ST_IDLE`: on end of number.
- `ST_PLAY` to `ST_IDLE`: when the last digit is consumed.

Top module: `redial_store`

## Requirements
- R1: After power-on reset no number is valid. `rd_avail_o` and `ovf_o` are 0, and a redial request leaves `rd_avail_o` at 0.
- R2: Digits strobed in from `ST_IDLE` are captured as a new number and committed when `num_end_i` is pulsed. A later redial presents them in entry order on `rd_digit_o` with `rd_avail_o` at 1. Each `rd_next_i` pulse advances to the next digit by the following cycle. `rd_digit_o` is 0 whenever `rd_avail_o` is 0.
- R3: `rd_last_o` is 1 exactly while the final stored digit is presented. After that digit is consumed, `rd_avail_o` returns to 0.
- R4: Digits of a number still being captured do not disturb the stored number. If capture is abandoned by standby, a later flash and redial present the previous number unchanged.
- R5: A redial starts at the read pointer, and the pointer is not rewound after a complete readout. A second redial then presents nothing. A flash returns the pointer to the first digit. A flash during capture also commits the digits captured so far.
- R6: The program key empties the stored number: a redial straight after it presents nothing. Digits keyed while programming are written directly into the stored number and are presented by a later redial.
- R7: Up to 23 digits are stored without setting `ovf_o`. A 24th digit is dropped and sets `ovf_o`. A number that overflowed is marked invalid on commit, and a redial of it presents nothing.
- R8: While `stby_i` is 1 all events are ignored, `rd_avail_o` is 0 and `ovf_o` is cleared. The stored digits, the validity mark and all three pointers are kept. A redial after standby continues from the retained read position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset; invalidates the stored number |
| stby_i | input | 1 | Standby; resets control, keeps digits and pointers |
| dig_stb_i | input | 1 | Digit strobe from the keypad path |
| dig_i | input | 4 | Digit code to store |
| prog_i | input | 1 | Program (notepad) key event |
| redial_i | input | 1 | Redial key event |
| flash_i | input | 1 | Flash key event |
| num_end_i | input | 1 | Dialling of the current number has ended |
| rd_next_i | input | 1 | Dial sequencer consumed the presented digit |
| rd_digit_o | output | 4 | Digit at the read pointer |
| rd_avail_o | output | 1 | A digit is being presented for redial |
| rd_last_o | output | 1 | The presented digit is the final one |
| ovf_o | output | 1 | More than 23 digits were keyed for the current number |

## Verification
A read pointer that drifts or is not rewound shows up at the next redial. The first digit presented is then wrong, missing or repeated, and `rd_last_o` appears on the wrong digit within the readout. A write pointer or commit fault changes the length or content of the replayed number, visible one cycle after the redial request. A validity flag in the wrong state shows as a redial that should be refused but starts, or the reverse, one cycle after the request. The directed scenarios read every digit back and compare against the sequence keyed.

// File: rtl/redial_pkg.sv
package redial_pkg;
    localparam int DIG_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DIAL,
        ST_NOTE,
        ST_PLAY
    } rdl_state_e;
endpackage

// File: rtl/redial_mem.sv
module redial_mem
    import redial_pkg::*;
#(
    parameter int DEPTH = 23,
    localparam int PW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic [DIG_W-1:0] wdata,
    input  logic             tmp_we,
    input  logic [PW-1:0]    tmp_addr,
    input  logic             main_we,
    input  logic [PW-1:0]    main_addr,
    input  logic             commit,
    input  logic [PW-1:0]    rd_addr,
    output logic [DIG_W-1:0] rd_data
);
    logic [DEPTH-1:0][DIG_W-1:0] scratch_q;
    logic [DEPTH-1:0][DIG_W-1:0] stored_q;

    always_ff @(posedge clk) begin
        if (tmp_we) begin
            scratch_q[tmp_addr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (commit) begin
            stored_q <= scratch_q;
        end else if (main_we) begin
            stored_q[main_addr] <= wdata;
        end
    end

    always_comb begin
        if (rd_addr < PW'(DEPTH)) begin
            rd_data = stored_q[rd_addr];
        end else begin
            rd_data = '0;
        end
    end
endmodule

// File: rtl/redial_ctrl.sv
module redial_ctrl
    import redial_pkg::*;
#(
    parameter int DEPTH = 23,
    localparam int PW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stby_i,
    input  logic          dig_stb_i,
    input  logic          prog_i,
    input  logic          redial_i,
    input  logic          flash_i,
    input  logic          num_end_i,
    input  logic          rd_next_i,
    output logic          tmp_we,
    output logic [PW-1:0] tmp_addr,
    output logic          main_we,
    output logic [PW-1:0] main_addr,
    output logic          commit,
    output logic [PW-1:0] rd_addr,
    output logic          avail,
    output logic          last,
    output logic          ovf
);
    localparam logic [PW-1:0] FULL = PW'(DEPTH);
    localparam logic [PW-1:0] ONE  = PW'(1);

    rdl_state_e    st_q, st_n;
    logic [PW-1:0] rac_q, rac_n;
    logic [PW-1:0] wac_q, wac_n;
    logic [PW-1:0] twac_q, twac_n;
    logic          ok_q, ok_n;
    logic          ovf_q, ovf_n;

    // State and pointer register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            rac_q  <= '0;
            wac_q  <= '0;
            twac_q <= '0;
            ok_q   <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            st_q   <= st_n;
            rac_q  <= rac_n;
            wac_q  <= wac_n;
            twac_q <= twac_n;
            ok_q   <= ok_n;
            ovf_q  <= ovf_n;
        end
    end

    // Next state, pointers and write strobes
    always_comb begin
        st_n    = st_q;
        rac_n   = rac_q;
        wac_n   = wac_q;
        twac_n  = twac_q;
        ok_n    = ok_q;
        ovf_n   = ovf_q;
        tmp_we  = 1'b0;
        main_we = 1'b0;
        commit  = 1'b0;
        if (stby_i) begin
            st_n  = ST_IDLE;
            ovf_n = 1'b0;
        end else if (flash_i) begin
            if (st_q == ST_DIAL) begin
                commit = 1'b1;
                wac_n  = twac_q;
                ok_n   = !ovf_q;
            end
            rac_n = '0;
            st_n  = ST_IDLE;
        end else if (prog_i) begin
            wac_n = '0;
            rac_n = '0;
            ok_n  = 1'b1;
            ovf_n = 1'b0;
            st_n  = ST_NOTE;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (redial_i) begin
                        if (ok_q && (rac_q < wac_q)) begin
                            st_n = ST_PLAY;
                        end
                    end else if (dig_stb_i) begin
                        tmp_we = 1'b1;
                        twac_n = ONE;
                        ovf_n  = 1'b0;
                        st_n   = ST_DIAL;
                    end
                end
                ST_DIAL: begin
                    if (num_end_i) begin
                        commit = 1'b1;
                        wac_n  = twac_q;
                        ok_n   = !ovf_q;
                        rac_n  = '0;
                        st_n   = ST_IDLE;
                    end else if (dig_stb_i) begin
                        if (twac_q < FULL) begin
                            tmp_we = 1'b1;
                            twac_n = twac_q + ONE;
                        end else begin
                            ovf_n = 1'b1;
                        end
                    end
                end
                ST_NOTE: begin
                    if (num_end_i) begin
                        st_n = ST_IDLE;
                    end else if (dig_stb_i) begin
                        if (wac_q < FULL) begin
                            main_we = 1'b1;
                            wac_n   = wac_q + ONE;
                        end else begin
                            ovf_n = 1'b1;
                            ok_n  = 1'b0;
                        end
                    end
                end
                ST_PLAY: begin
                    if (rd_next_i) begin
                        rac_n = rac_q + ONE;
                        if (rac_q + ONE >= wac_q) begin
                            st_n = ST_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        tmp_addr  = (st_q == ST_IDLE) ? '0 : twac_q;
        main_addr = wac_q;
        rd_addr   = rac_q;
        avail     = (st_q == ST_PLAY);
        last      = (st_q == ST_PLAY) && (rac_q + ONE == wac_q);
        ovf       = ovf_q;
    end

    // R5, R8: read pointer never passes the stored length
    a_r5_rac_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        rac_q <= wac_q);
    // R7: both write pointers stay within capacity
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (wac_q <= FULL) && (twac_q <= FULL));
    // R7: a dropped digit leaves the scratch pointer full
    a_r7_drop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!stby_i && !flash_i && !prog_i && !num_end_i && st_q == ST_DIAL
         && dig_stb_i && twac_q == FULL) |=> (twac_q == FULL) && ovf_q);
    // R8: standby keeps every pointer and the validity mark
    a_r8_standby_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        stby_i |=> $stable(rac_q) && $stable(wac_q) && $stable(twac_q)
                   && $stable(ok_q) && !avail);
    // R5: flash rewinds the read pointer
    a_r5_flash_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_i && !stby_i) |=> (rac_q == '0));
    // R1, R7: an invalid number is never presented
    a_r1_invalid_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (!ok_q && redial_i && st_q == ST_IDLE) |=> !avail);
    // R2: presentation only with a digit left
    a_r2_avail_digit: assert property (@(posedge clk) disable iff (!rst_n)
        avail |-> (rac_q < wac_q));
endmodule

// File: rtl/redial_store.sv
module redial_store
    import redial_pkg::*;
#(
    parameter int DEPTH = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stby_i,
    input  logic             dig_stb_i,
    input  logic [DIG_W-1:0] dig_i,
    input  logic             prog_i,
    input  logic             redial_i,
    input  logic             flash_i,
    input  logic             num_end_i,
    input  logic             rd_next_i,
    output logic [DIG_W-1:0] rd_digit_o,
    output logic             rd_avail_o,
    output logic             rd_last_o,
    output logic             ovf_o
);
    localparam int PW = $clog2(DEPTH + 1);

    logic          tmp_we, main_we, commit, avail;
    logic [PW-1:0] tmp_addr, main_addr, rd_addr;
    logic [DIG_W-1:0] rd_data;

    redial_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .stby_i    (stby_i),
        .dig_stb_i (dig_stb_i),
        .prog_i    (prog_i),
        .redial_i  (redial_i),
        .flash_i   (flash_i),
        .num_end_i (num_end_i),
        .rd_next_i (rd_next_i),
        .tmp_we    (tmp_we),
        .tmp_addr  (tmp_addr),
        .main_we   (main_we),
        .main_addr (main_addr),
        .commit    (commit),
        .rd_addr   (rd_addr),
        .avail     (avail),
        .last      (rd_last_o),
        .ovf       (ovf_o)
    );

    redial_mem #(.DEPTH(DEPTH)) u_mem (
        .clk       (clk),
        .wdata     (dig_i),
        .tmp_we    (tmp_we),
        .tmp_addr  (tmp_addr),
        .main_we   (main_we),
        .main_addr (main_addr),
        .commit    (commit),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    assign rd_avail_o = avail;
    assign rd_digit_o = avail ? rd_data : '0;
endmodule

// File: tb/redial_store_tb.sv
module redial_store_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stby_i = 1'b0, dig_stb_i = 1'b0, prog_i = 1'b0;
    logic       redial_i = 1'b0, flash_i = 1'b0, num_end_i = 1'b0, rd_next_i = 1'b0;
    logic [3:0] dig_i = 4'd0;
    logic [3:0] rd_digit_o;
    logic       rd_avail_o, rd_last_o, ovf_o;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [3:0] exp_d [0:31];
    int exp_n = 0;

    always #2.5 clk = ~clk;

    redial_store u_dut (
        .clk(clk), .rst_n(rst_n), .stby_i(stby_i), .dig_stb_i(dig_stb_i),
        .dig_i(dig_i), .prog_i(prog_i), .redial_i(redial_i), .flash_i(flash_i),
        .num_end_i(num_end_i), .rd_next_i(rd_next_i), .rd_digit_o(rd_digit_o),
        .rd_avail_o(rd_avail_o), .rd_last_o(rd_last_o), .ovf_o(ovf_o)
    );

    task automatic chk(input bit good, input string req, input int act, input int exp);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_redial(); @(negedge clk); redial_i = 1; @(negedge clk); redial_i = 0; endtask
    task automatic pulse_flash();  @(negedge clk); flash_i = 1;  @(negedge clk); flash_i = 0;  endtask
    task automatic pulse_prog();   @(negedge clk); prog_i = 1;   @(negedge clk); prog_i = 0;   endtask
    task automatic pulse_end();    @(negedge clk); num_end_i = 1; @(negedge clk); num_end_i = 0; endtask

    task automatic key_digits(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); dig_stb_i = 1; dig_i = exp_d[i % 32];
        end
        @(negedge clk); dig_stb_i = 0;
    endtask

    // Reads digits from index 'from' to exp_n-1 and checks each one
    task automatic read_back(input int from, input string req);
        for (int i = from; i < exp_n; i++) begin
            chk(rd_avail_o == 1'b1, req, rd_avail_o, 1);
            chk(rd_digit_o == exp_d[i], req, rd_digit_o, exp_d[i]);
            chk(rd_last_o == (i == exp_n - 1), "R3", rd_last_o, (i == exp_n - 1));
            @(negedge clk); rd_next_i = 1; @(negedge clk); rd_next_i = 0;
        end
        chk(rd_avail_o == 1'b0, "R3", rd_avail_o, 0);
    endtask

    task automatic t_reset();
        chk(rd_avail_o == 0, "R1", rd_avail_o, 0);
        chk(ovf_o == 0, "R1", ovf_o, 0);
        pulse_redial();
        chk(rd_avail_o == 0, "R1", rd_avail_o, 0);
        chk(rd_digit_o == 0, "R2", rd_digit_o, 0);
    endtask

    task automatic t_dial_redial();
        exp_d[0] = 5; exp_d[1] = 1; exp_d[2] = 2; exp_d[3] = 0; exp_d[4] = 9; exp_n = 5;
        key_digits(5);
        pulse_end();
        pulse_redial();
        read_back(0, "R2");
    endtask

    task automatic t_rewind();
        pulse_redial();
        chk(rd_avail_o == 0, "R5", rd_avail_o, 0);
        pulse_flash();
        pulse_redial();
        read_back(0, "R5");
    endtask

    task automatic t_scratch_isolated();
        logic [3:0] keep [0:4];
        for (int i = 0; i < 5; i++) keep[i] = exp_d[i];
        exp_d[0] = 7; exp_d[1] = 7; exp_d[2] = 3;
        key_digits(3);
        @(negedge clk); stby_i = 1; @(negedge clk); stby_i = 0;
        for (int i = 0; i < 5; i++) exp_d[i] = keep[i];
        pulse_flash();
        pulse_redial();
        read_back(0, "R4");
    endtask

    task automatic t_flash_commit();
        exp_d[0] = 4; exp_d[1] = 8; exp_n = 2;
        key_digits(2);
        pulse_flash();
        pulse_redial();
        read_back(0, "R5");
    endtask

    task automatic t_standby_resume();
        exp_d[0] = 6; exp_d[1] = 2; exp_d[2] = 11; exp_d[3] = 3; exp_n = 4;
        key_digits(4);
        pulse_end();
        pulse_redial();
        chk(rd_digit_o == 6, "R8", rd_digit_o, 6);
        @(negedge clk); rd_next_i = 1; @(negedge clk); rd_next_i = 0;
        @(negedge clk); stby_i = 1; redial_i = 1;
        @(negedge clk);
        chk(rd_avail_o == 0, "R8", rd_avail_o, 0);
        @(negedge clk); stby_i = 0; redial_i = 0;
        @(negedge clk);
        chk(rd_avail_o == 0, "R8", rd_avail_o, 0);
        pulse_redial();
        read_back(1, "R8");
    endtask

    task automatic t_notepad();
        pulse_prog();
        pulse_end();
        pulse_redial();
        chk(rd_avail_o == 0, "R6", rd_avail_o, 0);
        exp_d[0] = 3; exp_d[1] = 1; exp_d[2] = 4; exp_n = 3;
        pulse_prog();
        key_digits(3);
        pulse_end();
        pulse_redial();
        read_back(0, "R6");
    endtask

    task automatic t_por();
        @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
        t_reset();
    endtask

    task automatic t_capacity();
        for (int i = 0; i < 24; i++) exp_d[i] = 4'((i * 7 + 3) % 16);
        exp_n = 23;
        key_digits(23);
        chk(ovf_o == 0, "R7", ovf_o, 0);
        pulse_end();
        pulse_redial();
        read_back(0, "R7");
        key_digits(24);
        chk(ovf_o == 1, "R7", ovf_o, 1);
        pulse_end();
        pulse_flash();
        pulse_redial();
        chk(rd_avail_o == 0, "R7", rd_avail_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_dial_redial();
        t_rewind();
        t_scratch_isolated();
        t_flash_commit();
        t_standby_resume();
        t_notepad();
        t_por();
        t_capacity();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule